// File: doc/BRIEF.md
# Bridge Command Register with Upstream Request Gating

This block holds the 16-bit command word of a virtual PCI-to-PCI bridge port and applies the permissions it encodes. Software writes and reads the word through a small configuration port with a two-lane byte mask. Five bits are implemented: I/O space enable, memory space enable, bus master enable, parity error response enable and system error message enable. Every other bit reads as zero.

Requests that travel upstream from the secondary side pass through a one-entry registered stage with valid/ready handshakes. While bus mastering is enabled, they pass through unchanged. While it is disabled, every memory, I/O, peer and MSI request is still forwarded, but it is redirected to the fixed address 0xC0000. A write-type request also loses all of its byte enables. A read-type request is marked so that its transfer raises an Unsupported Request pulse. Completions are never gated.

On the downstream side, the block qualifies memory and I/O window hits with the space enables. It lets the master data parity error status be set only while parity error response is enabled. It raises an error-message pulse for primary-side errors when either the command word or the device-control reporting bit allows it. Secondary-side errors follow a separate enable.

Top module: `bridge_cmd_gate`

## Requirements
- R1: After reset the command word reads 0x0000. A write with cfg_be[0] set updates the writable bits among 7:0. A write with cfg_be[1] set updates the writable bits among 15:8. The writable bits are 0 (I/O enable), 1 (memory enable), 2 (bus master enable), 6 (parity response enable) and 8 (error message enable).
- R2: Bits 3, 4, 5, 7 and 15:9 always read as 0, whatever is written to them.
- R3: With bus master enable at 1, a request leaves with the kind, address and byte enables it arrived with.
- R4: With bus master enable at 0, a request of kind 0 (memory write), 2 (I/O write), 4 (MSI) or 5 (peer write) leaves with address 0xC0000 and byte enables 0.
- R5: With bus master enable at 0, a request of kind 1 (memory read), 3 (I/O read) or 6 (peer read) leaves with address 0xC0000 and its original byte enables.
- R6: A request of kind 7 (completion) leaves unchanged and never raises the Unsupported Request pulse, whatever bus master enable is.
- R7: dn_claim_mem equals (dn_hit_mem or dn_hit_pmem) and memory enable. dn_claim_io equals dn_hit_io and I/O enable.
- R8: Each accepted request produces exactly one output transfer, in acceptance order. us_in_ready is high when the stage is empty or us_out_ready is high.
- R9: us_ur_pulse is high for exactly the cycle in which a request gated under R5 transfers out. It is low at all other times.
- R10: sts_mdpe_set equals par_err_evt and parity response enable.
- R11: err_msg_pulse equals (pri_err_evt and (error message enable or devctl_rpt_en)) or (sec_err_evt and sec_rpt_en).
- R12: A command write takes effect from the cycle after the write. Gating is decided from the bus master enable value at the moment of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Command word write strobe |
| cfg_be | input | 2 | Byte lane mask for the write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Current command word |
| us_in_valid | input | 1 | Upstream request valid |
| us_in_ready | output | 1 | Upstream request accepted |
| us_in_kind | input | 3 | Request kind code (0..7) |
| us_in_addr | input | ADDR_W | Request address |
| us_in_be | input | BE_W | Request byte enables |
| us_out_valid | output | 1 | Filtered request valid |
| us_out_ready | input | 1 | Downstream of the filter can take it |
| us_out_kind | output | 3 | Filtered request kind |
| us_out_addr | output | ADDR_W | Filtered address |
| us_out_be | output | BE_W | Filtered byte enables |
| us_ur_pulse | output | 1 | Unsupported Request status for a gated read |
| dn_hit_mem | input | 1 | Memory window hit |
| dn_hit_pmem | input | 1 | Prefetchable window hit |
| dn_hit_io | input | 1 | I/O window hit |
| dn_claim_mem | output | 1 | Qualified memory claim |
| dn_claim_io | output | 1 | Qualified I/O claim |
| par_err_evt | input | 1 | Master data parity error event |
| sts_mdpe_set | output | 1 | Set strobe for the parity status bit |
| pri_err_evt | input | 1 | Primary-side error event |
| sec_err_evt | input | 1 | Secondary-side error event |
| devctl_rpt_en | input | 1 | Device-control reporting enable |
| sec_rpt_en | input | 1 | Secondary error forwarding enable |
| err_msg_pulse | output | 1 | Error message request |

## Verification
A corrupted command bit shows up on cfg_rdata on the next cycle. It then shows up in the first window claim, parity strobe or error pulse that depends on that bit. A wrong bus master value at acceptance appears one transfer later as an address other than 0xC0000, as byte enables that are cleared or kept wrongly, or as a missing or extra Unsupported Request pulse. A lost or stale occupancy flag in the output stage shows up at once as a wrong us_in_ready or us_out_valid. The reference model is compared every cycle, so each of these faults is caught in the first cycle it reaches a port.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  localparam int CMD_W    = 16;
  localparam int LANES    = CMD_W / 8;
  localparam int IOAE_B   = 0;
  localparam int MAE_B    = 1;
  localparam int BME_B    = 2;
  localparam int PERRE_B  = 6;
  localparam int SERRE_B  = 8;
  localparam logic [CMD_W-1:0] CMD_RW_MASK =
    (CMD_W'(1) << IOAE_B) | (CMD_W'(1) << MAE_B) | (CMD_W'(1) << BME_B) |
    (CMD_W'(1) << PERRE_B) | (CMD_W'(1) << SERRE_B);

  localparam logic [2:0] K_MEM_WR  = 3'd0;
  localparam logic [2:0] K_MEM_RD  = 3'd1;
  localparam logic [2:0] K_IO_WR   = 3'd2;
  localparam logic [2:0] K_IO_RD   = 3'd3;
  localparam logic [2:0] K_MSI     = 3'd4;
  localparam logic [2:0] K_PEER_WR = 3'd5;
  localparam logic [2:0] K_PEER_RD = 3'd6;
  localparam logic [2:0] K_CPL     = 3'd7;

  function automatic logic kind_is_read(logic [2:0] k);
    return (k == K_MEM_RD) || (k == K_IO_RD) || (k == K_PEER_RD);
  endfunction

  function automatic logic kind_is_gateable(logic [2:0] k);
    return k != K_CPL;
  endfunction

  // Byte-lane merge of a command write restricted to implemented bits.
  function automatic logic [CMD_W-1:0] cmd_merge(logic [CMD_W-1:0] old_v,
                                                 logic [CMD_W-1:0] new_v,
                                                 logic [LANES-1:0] be);
    logic [CMD_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++)
      if (be[i]) m[i*8 +: 8] = 8'hFF;
    m = m & CMD_RW_MASK;
    return (old_v & ~m) | (new_v & m);
  endfunction

endpackage

// File: rtl/bcg_cmd_reg.sv
module bcg_cmd_reg
  import bcg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic [CMD_W-1:0] wdata,
  output logic [CMD_W-1:0] cmd_q
);

  logic [CMD_W-1:0] cmd_nxt;

  always_comb begin
    cmd_nxt = cmd_q;
    if (we) cmd_nxt = cmd_merge(cmd_q, wdata, be);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_nxt;
  end

endmodule

// File: rtl/bcg_up_gate.sv
module bcg_up_gate
  import bcg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4,
  parameter logic [ADDR_W-1:0] BLOCK_ADDR = 'hC0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bme,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BE_W-1:0]   in_be,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [BE_W-1:0]   out_be,
  output logic              out_ur,
  output logic              gated_now
);

  function automatic logic [ADDR_W-1:0] rewrite_addr(logic g, logic [ADDR_W-1:0] a);
    return g ? BLOCK_ADDR : a;
  endfunction

  function automatic logic [BE_W-1:0] rewrite_be(logic g, logic [2:0] k, logic [BE_W-1:0] b);
    return (g && !kind_is_read(k)) ? '0 : b;
  endfunction

  logic              full_q;
  logic [2:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;
  logic              ur_q;
  logic              accept;

  assign in_ready  = !full_q || out_ready;
  assign accept    = in_valid && in_ready;
  assign gated_now = !bme && kind_is_gateable(in_kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      kind_q <= '0;
      addr_q <= '0;
      be_q   <= '0;
      ur_q   <= 1'b0;
    end else if (accept) begin
      full_q <= 1'b1;
      kind_q <= in_kind;
      addr_q <= rewrite_addr(gated_now, in_addr);
      be_q   <= rewrite_be(gated_now, in_kind, in_be);
      ur_q   <= gated_now && kind_is_read(in_kind);
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end

  assign out_valid = full_q;
  assign out_kind  = kind_q;
  assign out_addr  = addr_q;
  assign out_be    = be_q;
  assign out_ur    = full_q && out_ready && ur_q;

endmodule

// File: rtl/bcg_dn_gate.sv
module bcg_dn_gate (
  input  logic ioae,
  input  logic mae,
  input  logic perre,
  input  logic serre,
  input  logic hit_mem,
  input  logic hit_pmem,
  input  logic hit_io,
  output logic claim_mem,
  output logic claim_io,
  input  logic par_evt,
  output logic mdpe_set,
  input  logic pri_evt,
  input  logic sec_evt,
  input  logic devctl_en,
  input  logic sec_en,
  output logic err_msg
);

  assign claim_mem = (hit_mem || hit_pmem) && mae;
  assign claim_io  = hit_io && ioae;
  assign mdpe_set  = par_evt && perre;
  assign err_msg   = (pri_evt && (serre || devctl_en)) || (sec_evt && sec_en);

endmodule

// File: rtl/bridge_cmd_gate.sv
module bridge_cmd_gate
  import bcg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4,
  parameter logic [ADDR_W-1:0] BLOCK_ADDR = 'hC0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_be,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              us_in_valid,
  output logic              us_in_ready,
  input  logic [2:0]        us_in_kind,
  input  logic [ADDR_W-1:0] us_in_addr,
  input  logic [BE_W-1:0]   us_in_be,
  output logic              us_out_valid,
  input  logic              us_out_ready,
  output logic [2:0]        us_out_kind,
  output logic [ADDR_W-1:0] us_out_addr,
  output logic [BE_W-1:0]   us_out_be,
  output logic              us_ur_pulse,
  input  logic              dn_hit_mem,
  input  logic              dn_hit_pmem,
  input  logic              dn_hit_io,
  output logic              dn_claim_mem,
  output logic              dn_claim_io,
  input  logic              par_err_evt,
  output logic              sts_mdpe_set,
  input  logic              pri_err_evt,
  input  logic              sec_err_evt,
  input  logic              devctl_rpt_en,
  input  logic              sec_rpt_en,
  output logic              err_msg_pulse
);

  logic [CMD_W-1:0] cmd_q;
  logic             up_gated;

  bcg_cmd_reg u_cmd (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .be    (cfg_be),
    .wdata (cfg_wdata),
    .cmd_q (cmd_q)
  );

  assign cfg_rdata = cmd_q;

  bcg_up_gate #(
    .ADDR_W     (ADDR_W),
    .BE_W       (BE_W),
    .BLOCK_ADDR (BLOCK_ADDR)
  ) u_up (
    .clk       (clk),
    .rst_n     (rst_n),
    .bme       (cmd_q[BME_B]),
    .in_valid  (us_in_valid),
    .in_ready  (us_in_ready),
    .in_kind   (us_in_kind),
    .in_addr   (us_in_addr),
    .in_be     (us_in_be),
    .out_valid (us_out_valid),
    .out_ready (us_out_ready),
    .out_kind  (us_out_kind),
    .out_addr  (us_out_addr),
    .out_be    (us_out_be),
    .out_ur    (us_ur_pulse),
    .gated_now (up_gated)
  );

  bcg_dn_gate u_dn (
    .ioae      (cmd_q[IOAE_B]),
    .mae       (cmd_q[MAE_B]),
    .perre     (cmd_q[PERRE_B]),
    .serre     (cmd_q[SERRE_B]),
    .hit_mem   (dn_hit_mem),
    .hit_pmem  (dn_hit_pmem),
    .hit_io    (dn_hit_io),
    .claim_mem (dn_claim_mem),
    .claim_io  (dn_claim_io),
    .par_evt   (par_err_evt),
    .mdpe_set  (sts_mdpe_set),
    .pri_evt   (pri_err_evt),
    .sec_evt   (sec_err_evt),
    .devctl_en (devctl_rpt_en),
    .sec_en    (sec_rpt_en),
    .err_msg   (err_msg_pulse)
  );

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker
  import bcg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BLOCK_ADDR = 'hC0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cfg_rdata,
  input logic              us_in_valid,
  input logic              us_in_ready,
  input logic              up_gated,
  input logic              us_out_valid,
  input logic              us_out_ready,
  input logic [2:0]        us_out_kind,
  input logic [ADDR_W-1:0] us_out_addr,
  input logic              us_ur_pulse,
  input logic              dn_claim_mem,
  input logic              dn_claim_io,
  input logic              sts_mdpe_set
);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~CMD_RW_MASK) == '0);

  // R9
  ur_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    us_ur_pulse |-> (us_out_valid && us_out_ready && us_out_addr == BLOCK_ADDR));

  // R6
  cpl_no_ur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (us_out_valid && us_out_kind == K_CPL) |-> !us_ur_pulse);

  // R5
  gated_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (us_in_valid && us_in_ready && up_gated) |=> (us_out_valid && us_out_addr == BLOCK_ADDR));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (us_out_valid && !us_out_ready) |=> (us_out_valid && $stable(us_out_addr) && $stable(us_out_kind)));

  // R7
  mem_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_claim_mem |-> cfg_rdata[MAE_B]);

  // R7
  io_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_claim_io |-> cfg_rdata[IOAE_B]);

  // R10
  mdpe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_mdpe_set |-> cfg_rdata[PERRE_B]);

endmodule

bind bridge_cmd_gate bcg_checker #(
  .ADDR_W     (ADDR_W),
  .BLOCK_ADDR (BLOCK_ADDR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_rdata    (cfg_rdata),
  .us_in_valid  (us_in_valid),
  .us_in_ready  (us_in_ready),
  .up_gated     (up_gated),
  .us_out_valid (us_out_valid),
  .us_out_ready (us_out_ready),
  .us_out_kind  (us_out_kind),
  .us_out_addr  (us_out_addr),
  .us_ur_pulse  (us_ur_pulse),
  .dn_claim_mem (dn_claim_mem),
  .dn_claim_io  (dn_claim_io),
  .sts_mdpe_set (sts_mdpe_set)
);

// File: tb/bridge_cmd_gate_test.sv
module bridge_cmd_gate_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int BW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_be = 0; logic [15:0] cfg_wdata = 0;
  logic [15:0] cfg_rdata;
  logic us_in_valid = 0; logic us_in_ready;
  logic [2:0] us_in_kind = 0; logic [AW-1:0] us_in_addr = 0; logic [BW-1:0] us_in_be = 0;
  logic us_out_valid; logic us_out_ready = 0;
  logic [2:0] us_out_kind; logic [AW-1:0] us_out_addr; logic [BW-1:0] us_out_be;
  logic us_ur_pulse;
  logic dn_hit_mem = 0, dn_hit_pmem = 0, dn_hit_io = 0;
  logic dn_claim_mem, dn_claim_io;
  logic par_err_evt = 0, sts_mdpe_set;
  logic pri_err_evt = 0, sec_err_evt = 0, devctl_rpt_en = 0, sec_rpt_en = 0;
  logic err_msg_pulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_cmd_gate uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .us_in_valid(us_in_valid), .us_in_ready(us_in_ready), .us_in_kind(us_in_kind),
    .us_in_addr(us_in_addr), .us_in_be(us_in_be),
    .us_out_valid(us_out_valid), .us_out_ready(us_out_ready), .us_out_kind(us_out_kind),
    .us_out_addr(us_out_addr), .us_out_be(us_out_be), .us_ur_pulse(us_ur_pulse),
    .dn_hit_mem(dn_hit_mem), .dn_hit_pmem(dn_hit_pmem), .dn_hit_io(dn_hit_io),
    .dn_claim_mem(dn_claim_mem), .dn_claim_io(dn_claim_io),
    .par_err_evt(par_err_evt), .sts_mdpe_set(sts_mdpe_set),
    .pri_err_evt(pri_err_evt), .sec_err_evt(sec_err_evt),
    .devctl_rpt_en(devctl_rpt_en), .sec_rpt_en(sec_rpt_en),
    .err_msg_pulse(err_msg_pulse)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference model state
  int unsigned cmd_m = 0;
  int unsigned qk[$];
  int unsigned qa[$];
  int unsigned qb[$];
  bit          qu[$];
  string       qt[$];
  bit acc_seen = 0;
  bit wrote_last = 0;

  task automatic check(bit ok, string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_rd(int unsigned k);
    return (k == 1) || (k == 3) || (k == 6);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      cmd_m = 0; qk.delete(); qa.delete(); qb.delete(); qu.delete(); qt.delete();
      acc_seen = 0; wrote_last = 0;
    end else if (!finished) begin
      bit exp_rdy, fire, bme, mae, ioae, perre, serre, exp_cm, exp_ci;
      string ctag;
      exp_rdy = (qk.size() == 0) || us_out_ready;
      fire = (qk.size() != 0) && us_out_ready;
      bme = cmd_m[2]; mae = cmd_m[1]; ioae = cmd_m[0]; perre = cmd_m[6]; serre = cmd_m[8];

      check(cfg_rdata == 16'(cmd_m), "R1", cfg_rdata, cmd_m);
      check(cfg_rdata[15:9] == 0 && cfg_rdata[7] == 0 && cfg_rdata[5:3] == 0, "R2", cfg_rdata, cmd_m);
      check(us_out_valid == (qk.size() != 0), "R8", us_out_valid, qk.size() != 0);
      check(us_in_ready == exp_rdy, "R8", us_in_ready, exp_rdy);
      check(us_ur_pulse == (fire && qu[0]), "R9", us_ur_pulse, fire && qu[0]);
      if (fire) begin
        check(us_out_kind == 3'(qk[0]), qt[0], us_out_kind, qk[0]);
        check(us_out_addr == AW'(qa[0]), qt[0], us_out_addr, qa[0]);
        check(us_out_be == BW'(qb[0]), qt[0], us_out_be, qb[0]);
      end
      exp_cm = (dn_hit_mem || dn_hit_pmem) && mae;
      exp_ci = dn_hit_io && ioae;
      ctag = wrote_last ? "R12" : "R7";
      check(dn_claim_mem == exp_cm, ctag, dn_claim_mem, exp_cm);
      check(dn_claim_io == exp_ci, ctag, dn_claim_io, exp_ci);
      check(sts_mdpe_set == (par_err_evt && perre), "R10", sts_mdpe_set, par_err_evt && perre);
      check(err_msg_pulse == ((pri_err_evt && (serre || devctl_rpt_en)) || (sec_err_evt && sec_rpt_en)),
            "R11", err_msg_pulse, (pri_err_evt && (serre || devctl_rpt_en)) || (sec_err_evt && sec_rpt_en));

      // advance model to the next edge
      if (fire) begin
        void'(qk.pop_front()); void'(qa.pop_front()); void'(qb.pop_front());
        void'(qu.pop_front()); void'(qt.pop_front());
      end
      acc_seen = us_in_valid && exp_rdy;
      if (acc_seen) begin
        int unsigned k, a, b;
        bit u;
        string t;
        k = us_in_kind; a = us_in_addr; b = us_in_be; u = 0;
        if (k == 7) t = "R6";
        else if (bme) t = "R3";
        else begin
          a = 32'h000C_0000;
          if (is_rd(k)) begin u = 1; t = "R5"; end
          else begin b = 0; t = "R4"; end
        end
        qk.push_back(k); qa.push_back(a); qb.push_back(b); qu.push_back(u); qt.push_back(t);
      end
      wrote_last = cfg_we;
      if (cfg_we) begin
        int unsigned m;
        m = 0;
        if (cfg_be[0]) m |= 32'h00FF;
        if (cfg_be[1]) m |= 32'hFF00;
        m &= 32'h0147;
        cmd_m = (cmd_m & ~m) | (cfg_wdata & m);
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset value and R8 empty stage after reset
    check(cfg_rdata == 16'h0000, "R1", cfg_rdata, 0);
    check(us_out_valid == 1'b0, "R8", us_out_valid, 0);

    // Directed: upper lane only, then all lanes of ones, with a memory hit pending (R12)
    @(posedge clk); #1;
    cfg_we = 1; cfg_be = 2'b10; cfg_wdata = 16'hFFFF; dn_hit_mem = 1;
    @(posedge clk); #1;
    cfg_be = 2'b11;
    @(posedge clk); #1;
    cfg_we = 0;
    // Gated traffic: clear bus master enable, keep windows open
    @(posedge clk); #1;
    cfg_we = 1; cfg_be = 2'b01; cfg_wdata = 16'h0003;
    @(posedge clk); #1;
    cfg_we = 0;

    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(posedge clk); #1;
      if (!us_in_valid || acc_seen) begin
        us_in_valid = ($urandom % 10) < 6;
        us_in_kind  = 3'($urandom);
        us_in_addr  = $urandom;
        us_in_be    = BW'($urandom);
      end
      us_out_ready = ($urandom % 10) < 7;
      cfg_we    = ($urandom % 30) == 0;
      cfg_be    = 2'($urandom);
      cfg_wdata = 16'($urandom);
      dn_hit_mem = 1'($urandom); dn_hit_pmem = 1'($urandom); dn_hit_io = 1'($urandom);
      par_err_evt = 1'($urandom); pri_err_evt = 1'($urandom); sec_err_evt = 1'($urandom);
      devctl_rpt_en = 1'($urandom); sec_rpt_en = 1'($urandom);
    end

    // drain
    @(posedge clk); #1;
    if (acc_seen) us_in_valid = 0;
    us_out_ready = 1; cfg_we = 0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      if (acc_seen) us_in_valid = 0;
    end
    @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

endmodule